// File: doc/BRIEF.md
# Management-Interface PHY Register Responder

This block stands in for the station-management path between a MAC and its PHY. Software sees two 16-bit registers behind a 32-bit write/read port: a command word and a data word. Writing the command word with its go bit set starts one PHY register access. Each access names a 5-bit PHY address and a 5-bit register index, and it either stores the data word into the PHY register or loads the PHY register into the data word. The go bit reads back as one while the access runs. The access takes a fixed number of cycles, and the go bit then clears itself.

The responding PHY is a small register file that exists only at PHY address 0. It mimics the side effects a real PHY shows on its basic control register. The reset and restart-negotiation bits never stick. Enabling autonegotiation makes negotiation finish at once. The link-up and negotiation-done status bits follow a link input. Serial clock and data pin timing is not modelled: the access latency is a parameter.

Top module: `mgmt_phy_resp`

## Requirements
- R1: After reset, the command and data words read 0. The PHY 0 registers hold: index 0 (control) 0x1140, index 1 (status) 0x790D, index 2 0x0362, index 3 0x5E6A, index 4 0x01E1, index 5 (partner ability) 0x45E1, and every other index 0.
- R2: In the command word, bit 0 is go/busy, bit 1 selects write (1) or read (0), bits 10:6 are the register index and bits 15:11 the PHY address. A write with bit 0 set, made while idle, starts an access. Bit 0 then reads 1 for exactly ACC_LAT cycles after the write edge and 0 afterwards. The other stored bits read back unchanged.
- R3: When a write access completes, the data word is stored into the selected register of PHY 0.
- R4: When a read access completes, the data word takes the value of the selected register.
- R5: A write to control register index 0 stores the value with bit 15 (reset) and bit 9 (restart negotiation) forced to 0.
- R6: If a control write leaves bit 12 (negotiation enable) set while status bit 5 (negotiation done) is 0, status bit 5 becomes 1 and register 5 becomes 0. If status bit 5 is already 1, register 5 is left alone.
- R7: On every change of the link input, status bit 2 (link up) and status bit 5 both take the new link value one cycle later. If an access that writes the status register completes in that same cycle, these two bits still take the link value.
- R8: PHY addresses other than 0 have no registers. Reads from them return 0, and writes to them change nothing.
- R9: While an access is running, port writes to either word are ignored. A command write with bit 0 clear stores the word and starts no access.
- R10: Port write bits 31:16 are ignored, and read bits 31:16 are 0. Port select 0 addresses the command word and 1 the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Port write strobe |
| wr_sel | input | 1 | Write target: 0 command word, 1 data word |
| wr_data | input | BUS_W | Write value |
| rd_sel | input | 1 | Read target: 0 command word, 1 data word |
| rd_data | output | BUS_W | Selected word, zero-extended |
| link_up | input | 1 | Link state from the medium |

## Verification
Two functions can land on the same clock edge. One is a link-input change; the other is the completion of a write access that targets the status register, and both update status bits 2 and 5. The bench provokes the clash in two steps. It starts a write of 0x0000 to status index 1 on PHY 0, then raises the link input in the cycle just before the completion edge. It judges the outcome by reading the status register back through a later read access, which must return 0x0024. A behavioural model runs beside the design and is compared with the read port on every clock, so the same clash is also judged cycle by cycle.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    localparam int REG_W    = 16;
    localparam int FIELD_W  = 5;
    localparam int NUM_REGS = 1 << FIELD_W;

    // register indices inside the PHY
    localparam logic [FIELD_W-1:0] RN_CTRL = 5'd0;
    localparam logic [FIELD_W-1:0] RN_STAT = 5'd1;
    localparam logic [FIELD_W-1:0] RN_ID1  = 5'd2;
    localparam logic [FIELD_W-1:0] RN_ID2  = 5'd3;
    localparam logic [FIELD_W-1:0] RN_ADV  = 5'd4;
    localparam logic [FIELD_W-1:0] RN_LPA  = 5'd5;

    // bit positions
    localparam int CTRL_RESET_BIT  = 15;
    localparam int CTRL_ANEN_BIT   = 12;
    localparam int CTRL_ANRST_BIT  = 9;
    localparam int STAT_ANDONE_BIT = 5;
    localparam int STAT_LINK_BIT   = 2;

    // command word as seen on the register port
    typedef struct packed {
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regnum;
        logic [3:0]         rsv;
        logic               wr;
        logic               busy;
    } mgmt_cmd_t;

    // access request handed to the PHY model on completion
    typedef struct packed {
        logic               go;
        logic               wr;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regnum;
        logic [REG_W-1:0]   wdata;
    } phy_req_t;

    function automatic logic [REG_W-1:0] phy_reset_value(input logic [FIELD_W-1:0] idx);
        case (idx)
            RN_CTRL: return 16'h1140;
            RN_STAT: return 16'h790D;
            RN_ID1:  return 16'h0362;
            RN_ID2:  return 16'h5E6A;
            RN_ADV:  return 16'h01E1;
            RN_LPA:  return 16'h45E1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] ctrl_sanitize(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        r = v;
        r[CTRL_RESET_BIT] = 1'b0;
        r[CTRL_ANRST_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import mdio_resp_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_word,
    input  logic [REG_W-1:0] phy_rdata,
    output phy_req_t         req,
    output logic [REG_W-1:0] cmd_view,
    output logic [REG_W-1:0] data_view
);

    localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LAT - 1);

    mgmt_cmd_t        cmd_q;
    logic [REG_W-1:0] data_q;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done;

    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
            if (!cmd_q.wr) begin
                data_q <= phy_rdata;
            end
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (wr_en) begin
            if (wr_sel) begin
                data_q <= wr_word;
            end else begin
                cmd_q      <= wr_word;
                cmd_q.busy <= 1'b0;
                if (wr_word[0]) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_LOAD;
                end
            end
        end
    end

    always_comb begin
        req.go     = done;
        req.wr     = cmd_q.wr;
        req.phy    = cmd_q.phy;
        req.regnum = cmd_q.regnum;
        req.wdata  = data_q;
    end

    assign cmd_view  = {cmd_q[REG_W-1:1], busy_q};
    assign data_view = data_q;

    p_busy_clears_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);

    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> ($stable(cmd_q) && $stable(data_q)));

    p_foreign_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_q.wr && cmd_q.phy != '0) |=> (data_q == '0));

endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
    import mdio_resp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phy_req_t         req,
    input  logic             link_up,
    output logic [REG_W-1:0] rdata
);

    logic [REG_W-1:0] mem [NUM_REGS];
    logic             link_q;
    logic             hit;
    logic             ctrl_hit;
    logic [REG_W-1:0] ctrl_val;
    logic             an_kick;
    logic             link_evt;

    assign hit      = req.go && req.wr && (req.phy == '0);
    assign ctrl_hit = hit && (req.regnum == RN_CTRL);
    assign ctrl_val = ctrl_sanitize(req.wdata);
    assign an_kick  = ctrl_hit && ctrl_val[CTRL_ANEN_BIT] && !mem[RN_STAT][STAT_ANDONE_BIT];
    assign link_evt = (link_up != link_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= phy_reset_value(FIELD_W'(i));
            end
            link_q <= 1'b0;
        end else begin
            link_q <= link_up;
            if (hit) begin
                mem[req.regnum] <= ctrl_hit ? ctrl_val : req.wdata;
            end
            if (an_kick) begin
                mem[RN_STAT][STAT_ANDONE_BIT] <= 1'b1;
                mem[RN_LPA]                   <= '0;
            end
            // link change is applied last so it wins over a same-cycle write
            if (link_evt) begin
                mem[RN_STAT][STAT_LINK_BIT]   <= link_up;
                mem[RN_STAT][STAT_ANDONE_BIT] <= link_up;
            end
        end
    end

    assign rdata = (req.phy == '0) ? mem[req.regnum] : '0;

    p_ctrl_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |=> (!mem[RN_CTRL][CTRL_RESET_BIT] && !mem[RN_CTRL][CTRL_ANRST_BIT]));

    p_an_complete_r6: assert property (@(posedge clk) disable iff (rst)
        (an_kick && !link_evt) |=> (mem[RN_STAT][STAT_ANDONE_BIT] && mem[RN_LPA] == '0));

    p_link_follow_r7: assert property (@(posedge clk) disable iff (rst)
        link_evt |=> (mem[RN_STAT][STAT_LINK_BIT] == $past(link_up)
                      && mem[RN_STAT][STAT_ANDONE_BIT] == $past(link_up)));

    p_foreign_write_r8: assert property (@(posedge clk) disable iff (rst)
        (req.go && req.phy != '0 && !link_evt) |=> ($stable(mem[RN_CTRL]) && $stable(mem[RN_STAT])));

endmodule

// File: rtl/mgmt_phy_resp.sv
module mgmt_phy_resp
    import mdio_resp_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int ACC_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [BUS_W-1:0] rd_data,
    input  logic             link_up
);

    phy_req_t         req;
    logic [REG_W-1:0] phy_rdata;
    logic [REG_W-1:0] cmd_view;
    logic [REG_W-1:0] data_view;
    logic             unused_upper;

    assign unused_upper = ^wr_data[BUS_W-1:REG_W];

    mgmt_seq #(
        .ACC_LAT (ACC_LAT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_word   (wr_data[REG_W-1:0]),
        .phy_rdata (phy_rdata),
        .req       (req),
        .cmd_view  (cmd_view),
        .data_view (data_view)
    );

    phy_regfile u_phy (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .link_up (link_up),
        .rdata   (phy_rdata)
    );

    assign rd_data = BUS_W'(rd_sel ? data_view : cmd_view);

endmodule

// File: tb/mgmt_phy_resp_bench.sv
`timescale 1ns/1ps
module mgmt_phy_resp_bench;

    localparam int BW  = 32;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic          rd_sel = 1'b0;
    logic [BW-1:0] rd_data;
    logic          link_up = 1'b0;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    mgmt_phy_resp #(.BUS_W(BW), .ACC_LAT(LAT)) u_mgmt_phy_resp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .link_up(link_up)
    );

    // behavioural reference model
    int          m_rem;
    logic [15:0] m_cmd, m_data;
    logic [15:0] m_phy [32];
    logic        m_lq;

    function automatic logic [15:0] init_val(int i);
        case (i)
            0: return 16'h1140;  1: return 16'h790D;
            2: return 16'h0362;  3: return 16'h5E6A;
            4: return 16'h01E1;  5: return 16'h45E1;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0; m_cmd = 0; m_data = 0; m_lq = 0;
            for (int i = 0; i < 32; i++) m_phy[i] = init_val(i);
        end else begin
            if (m_rem > 0) begin
                if (m_rem == 1) begin
                    int p, r;
                    logic [15:0] v;
                    p = int'(m_cmd[15:11]);
                    r = int'(m_cmd[10:6]);
                    if (m_cmd[1]) begin
                        if (p == 0) begin
                            if (r == 0) begin
                                v = m_data & 16'h7DFF;
                                if (v[12] && !m_phy[1][5]) begin
                                    m_phy[1][5] = 1'b1;
                                    m_phy[5] = 16'h0000;
                                end
                                m_phy[0] = v;
                            end else begin
                                m_phy[r] = m_data;
                            end
                        end
                    end else begin
                        m_data = (p == 0) ? m_phy[r] : 16'h0000;
                    end
                end
                m_rem = m_rem - 1;
            end else if (wr_en) begin
                if (wr_sel) m_data = wr_data[15:0];
                else begin
                    m_cmd = wr_data[15:0] & 16'hFFFE;
                    if (wr_data[0]) m_rem = LAT;
                end
            end
            if (link_up != m_lq) begin
                m_phy[1][2] = link_up;
                m_phy[1][5] = link_up;
            end
            m_lq = link_up;
        end
    end

    // per-clock comparison of the read port against the model
    always @(posedge clk) begin
        #2;
        if (!rst && !finished) begin
            logic [31:0] exp;
            exp = rd_sel ? {16'h0, m_data} : {16'h0, m_cmd[15:1], (m_rem > 0)};
            checks++;
            if (rd_data !== exp) begin
                failures++;
                $display("FAIL R2/R4 model stream: actual=%h expected=%h at %0t", rd_data, exp, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int p, int r, bit w, bit b);
        return {16'h0, 5'(p), 5'(r), 4'h0, w, b};
    endfunction

    task automatic reg_wr(input bit sel, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic phy_rd(input int p, input int r, output logic [31:0] val);
        reg_wr(1'b0, mk(p, r, 1'b0, 1'b1));
        repeat (LAT) @(negedge clk);
        rd_sel = 1'b1;
        #1 val = rd_data;
    endtask

    task automatic phy_wr(input int p, input int r, input logic [15:0] v);
        reg_wr(1'b1, {16'h0, v});
        reg_wr(1'b0, mk(p, r, 1'b1, 1'b1));
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_sel = 1'b0; #1 chk("R1 command word after reset", rd_data, 32'h0);
        rd_sel = 1'b1; #1 chk("R1 data word after reset", rd_data, 32'h0);

        // R1 reset contents, read through R4 accesses
        phy_rd(0, 0, v); chk("R1 control reset", v, 32'h1140);
        phy_rd(0, 1, v); chk("R1 status reset", v, 32'h790D);
        phy_rd(0, 2, v); chk("R1 id1 reset", v, 32'h0362);
        phy_rd(0, 3, v); chk("R1 id2 reset", v, 32'h5E6A);
        phy_rd(0, 4, v); chk("R1 advert reset", v, 32'h01E1);
        phy_rd(0, 5, v); chk("R1 partner reset", v, 32'h45E1);
        phy_rd(0, 9, v); chk("R1 other index zero", v, 32'h0);

        // R2 busy lasts exactly LAT cycles
        @(negedge clk); rd_sel = 1'b0;
        reg_wr(1'b0, mk(0, 2, 1'b0, 1'b1));
        for (int k = 0; k < LAT; k++) begin
            if (k > 0) @(negedge clk);
            #1 chk("R2 busy while running", {31'h0, rd_data[0]}, 32'h1);
        end
        @(negedge clk);
        #1 chk("R2 command after completion", rd_data, mk(0, 2, 1'b0, 1'b0));

        // R3 writes
        phy_wr(0, 7, 16'hA5C3);
        phy_rd(0, 7, v); chk("R3 write then read idx7", v, 32'hA5C3);
        phy_wr(0, 16, 16'hFFFF);
        phy_rd(0, 16, v); chk("R3 write then read idx16", v, 32'hFFFF);

        // R5 self-clearing control bits
        phy_wr(0, 0, 16'h8300);
        phy_rd(0, 0, v); chk("R5 control reset/restart cleared", v, 32'h0100);
        phy_rd(0, 1, v); chk("R6 no negotiation without enable", v, 32'h790D);

        // R6 instant negotiation completion
        phy_wr(0, 0, 16'h9000);
        phy_rd(0, 0, v); chk("R5 control with enable", v, 32'h1000);
        phy_rd(0, 1, v); chk("R6 done flag set", v, 32'h792D);
        phy_rd(0, 5, v); chk("R6 partner cleared", v, 32'h0);
        phy_wr(0, 5, 16'h1234);
        phy_wr(0, 0, 16'h1000);
        phy_rd(0, 5, v); chk("R6 partner kept when already done", v, 32'h1234);

        // R7 link follow
        @(negedge clk); link_up = 1'b1;
        repeat (2) @(negedge clk);
        phy_rd(0, 1, v); chk("R7 link up", v, 32'h792D);
        @(negedge clk); link_up = 1'b0;
        repeat (2) @(negedge clk);
        phy_rd(0, 1, v); chk("R7 link down", v, 32'h7909);

        // R7 clash: link rises on the completion edge of a status write
        reg_wr(1'b1, 32'h0);
        reg_wr(1'b0, mk(0, 1, 1'b1, 1'b1));
        repeat (LAT - 1) @(negedge clk);
        link_up = 1'b1;
        @(negedge clk);
        phy_rd(0, 1, v); chk("R7 link wins same-cycle write", v, 32'h0024);

        // R8 foreign PHY address
        phy_wr(3, 0, 16'hFFFF);
        phy_rd(3, 0, v); chk("R8 foreign read zero", v, 32'h0);
        phy_rd(0, 0, v); chk("R8 foreign write discarded", v, 32'h1000);

        // R9 writes ignored while busy
        reg_wr(1'b0, mk(0, 2, 1'b0, 1'b1));
        reg_wr(1'b1, 32'h0000DEAD);
        reg_wr(1'b0, mk(0, 7, 1'b1, 1'b1));
        repeat (LAT - 2) @(negedge clk);
        rd_sel = 1'b1; #1 chk("R9 data write ignored while busy", rd_data, 32'h0362);
        rd_sel = 1'b0; #1 chk("R9 command write ignored while busy", rd_data, mk(0, 2, 1'b0, 1'b0));
        phy_rd(0, 7, v); chk("R9 ignored command did not run", v, 32'hA5C3);
        reg_wr(1'b0, mk(0, 5, 1'b1, 1'b0));
        repeat (LAT) @(negedge clk);
        rd_sel = 1'b0; #1 chk("R9 stored without go", rd_data, mk(0, 5, 1'b1, 1'b0));
        rd_sel = 1'b1; #1 chk("R9 no access without go", rd_data, 32'hA5C3);

        // R10 upper bits
        reg_wr(1'b1, 32'hFFFF1234);
        rd_sel = 1'b1; #1 chk("R10 upper bits dropped", rd_data, 32'h00001234);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule